// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the hardware translator that a memory management unit starts after a TLB miss. It accepts a 20-bit virtual page number, which is bits 31:12 of a 32-bit virtual address. It then walks a two-level page table held in memory and hands back a 28-bit physical page number for a 40-bit physical space, a page-size flag and a fault flag. The first-level table base comes from a 27-bit pointer register. The walker extends that value with 13 zero bits, so every first-level table starts on an 8 KB boundary. A first-level entry either maps a 2 MB page directly, which ends the walk after one read, or points to a 4 KB-aligned second-level table whose entry maps a 4 KB page.

There are three valid/ready edges. The miss request is accepted only while the walker is idle (`walk_ready_o` high), so only one walk is in flight at a time. The requester may hold `walk_valid_i` as long as it likes. Table reads leave on a request channel that holds its address and size stable until `mem_req_ready_i` is seen. Each read gets exactly one `mem_rsp_valid_i` pulse back. That pulse is honoured only while a read is outstanding. The result is presented with `res_valid_o` and held unchanged until the consumer raises `res_ready_i`. The walker stays busy until then, so downstream back-pressure stalls new walks.

Top module: `pt_walker`

## Requirements
- R1: After reset, `walk_ready_o` is 1 and both `mem_req_valid_o` and `res_valid_o` are 0.
- R2: A walk is accepted on a clock edge where `walk_valid_i` and `walk_ready_o` are both 1. `walk_ready_o` then stays 0 until the result has been taken, and it is never 1 while a read request or a result is pending.
- R3: In the cycle after acceptance the walker requests a 4-byte read (`mem_req_wide_o` = 0) at address {base, vpn[19:9], 2'b00}, where base is the 27-bit pointer value. Any request keeps its address and size stable until `mem_req_ready_i` is 1.
- R4: The first-level entry is `mem_rsp_data_i[31:0]`. Bit 31 is the valid flag. If it is 0, the walker ends with `res_fault_o` = 1, `res_big_o` = 0 and `res_ppn_o` = 0, and it issues no second read.
- R5: A valid first-level entry with bit 30 set maps a 2 MB page. The walker ends without a second read, with `res_big_o` = 1, `res_fault_o` = 0 and `res_ppn_o` = {entry[18:0], vpn[8:0]}. Entry bits 29:19 are ignored.
- R6: A valid first-level entry with bit 30 clear points to a second-level table. In the cycle after the response, the walker requests an 8-byte read (`mem_req_wide_o` = 1) at {entry[27:0], vpn[8:0], 3'b000}.
- R7: The second-level entry is the 64-bit response. Bit 63 is its valid flag and bits 27:0 are the physical page number. A valid entry ends with `res_ppn_o` = entry[27:0], `res_big_o` = 0 and `res_fault_o` = 0.
- R8: A second-level entry with bit 63 clear ends the walk with `res_fault_o` = 1, `res_big_o` = 0 and `res_ppn_o` = 0.
- R9: `res_valid_o` rises in the cycle after the final response. The result stays stable until `res_ready_i` is 1, and in the cycle after that hand-off the walker is idle again.
- R10: A `mem_rsp_valid_i` pulse while no read is outstanding changes neither the walk nor the result. This covers pulses while idle, while a request waits for ready, and while a result is held.
- R11: The pointer register and the page number are sampled at acceptance. Changing them during a walk does not alter the read addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_valid_i | input | 1 | TLB miss request valid |
| walk_ready_o | output | 1 | Walker idle, request can be accepted |
| walk_vpn_i | input | 20 | Virtual page number (VA[31:12]) to translate |
| base_reg_i | input | 27 | Page table pointer register (upper bits of first-level base) |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 40 | Physical byte address of the table entry |
| mem_req_wide_o | output | 1 | 0 = 4-byte first-level read, 1 = 8-byte second-level read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data; first-level entries in bits 31:0 |
| res_valid_o | output | 1 | Translation result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| res_ppn_o | output | 28 | Physical page number, 4 KB granular |
| res_big_o | output | 1 | 1 when the mapping is a 2 MB page |
| res_fault_o | output | 1 | 1 when an invalid entry ended the walk |

## Verification
The bench goes after the early exit at the first level. A walker that ignored the big-page bit would issue a spurious wide read and stall waiting for data that never arrives. A walker that used the wrong virtual bits as offset would give a wrong page number. Invalid entries at both levels are checked for a zeroed result and a missing second read. A design that leaked the entry's page bits into a faulting result would be caught here. Stray response pulses during request stalls and result holds are injected, along with mid-walk changes to the pointer register and page number. A walker that sampled data at the wrong time or re-read its inputs would corrupt addresses or results. Address extremes (all-ones base and pointer, all-ones and all-zeros page numbers) expose truncation in the shift-and-concatenate address forming.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  // Chip-level translation geometry
  localparam int VA_W      = 32;
  localparam int PA_W      = 40;
  localparam int PG_W      = 12;
  localparam int L1_IDX_W  = 11;
  localparam int L2_IDX_W  = 9;
  localparam int L1_ENT_LG = 2;   // log2 of first-level entry bytes
  localparam int L2_ENT_LG = 3;   // log2 of second-level entry bytes

  // Derived widths
  localparam int VPN_W     = VA_W - PG_W;                     // 20
  localparam int BASE_W    = PA_W - L1_IDX_W - L1_ENT_LG;     // 27
  localparam int PPN_W     = PA_W - PG_W;                     // 28
  localparam int PTR_W     = PA_W - PG_W;                     // 28
  localparam int BIG_OFF_W = PG_W + L2_IDX_W;                 // 21
  localparam int BIG_PPN_W = PA_W - BIG_OFF_W;                // 19
  localparam int L1_ENT_W  = 8 << L1_ENT_LG;                  // 32
  localparam int L2_ENT_W  = 8 << L2_ENT_LG;                  // 64
  localparam int RSP_W     = L2_ENT_W;

  // Entry bit positions
  localparam int L1_V_BIT   = L1_ENT_W - 1;
  localparam int L1_BIG_BIT = L1_ENT_W - 2;
  localparam int L2_V_BIT   = L2_ENT_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT, L1_LEAF, L1_TABLE
  } l1_kind_e;

  typedef struct packed {
    logic             fault;
    logic             big;
    logic [PPN_W-1:0] ppn;
  } walk_result_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  logic [BASE_W-1:0] base_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              sel_l2_i,
  output logic [PA_W-1:0]   addr_o,
  output logic              wide_o
);
  logic [L1_IDX_W-1:0] l1_idx;
  logic [L2_IDX_W-1:0] l2_idx;
  logic [PA_W-1:0]     l1_addr;
  logic [PA_W-1:0]     l2_addr;

  assign l1_idx  = vpn_i[VPN_W-1 -: L1_IDX_W];
  assign l2_idx  = vpn_i[L2_IDX_W-1:0];
  // base register shifted out to a table start on an 8 KB boundary
  assign l1_addr = {base_i, l1_idx, {L1_ENT_LG{1'b0}}};
  // second-level pointer extended to a 4 KB aligned table start
  assign l2_addr = {ptr_i, l2_idx, {L2_ENT_LG{1'b0}}};

  assign addr_o = sel_l2_i ? l2_addr : l1_addr;
  assign wide_o = sel_l2_i;
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
(
  input  logic [RSP_W-1:0] data_i,
  input  logic [VPN_W-1:0] vpn_i,
  output l1_kind_e         l1_kind_o,
  output logic [PTR_W-1:0] l1_ptr_o,
  output walk_result_t     l1_res_o,
  output walk_result_t     l2_res_o
);
  logic [L1_ENT_W-1:0] l1_word;
  logic                unused_bits;

  assign l1_word     = data_i[L1_ENT_W-1:0];
  assign unused_bits = ^{data_i[L2_V_BIT-1:PPN_W]};

  always_comb begin
    l1_ptr_o = l1_word[PTR_W-1:0];
    l1_res_o = '0;
    if (!l1_word[L1_V_BIT]) begin
      l1_kind_o      = L1_FAULT;
      l1_res_o.fault = 1'b1;
    end else if (l1_word[L1_BIG_BIT]) begin
      l1_kind_o    = L1_LEAF;
      l1_res_o.big = 1'b1;
      l1_res_o.ppn = {l1_word[BIG_PPN_W-1:0], vpn_i[L2_IDX_W-1:0]};
    end else begin
      l1_kind_o = L1_TABLE;
    end
  end

  always_comb begin
    l2_res_o = '0;
    if (data_i[L2_V_BIT]) l2_res_o.ppn = data_i[PPN_W-1:0];
    else                  l2_res_o.fault = 1'b1;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_valid_i,
  input  logic [VPN_W-1:0]  walk_vpn_i,
  input  logic [BASE_W-1:0] base_reg_i,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  l1_kind_e          l1_kind_i,
  input  logic [PTR_W-1:0]  l1_ptr_i,
  input  walk_result_t      l1_res_i,
  input  walk_result_t      l2_res_i,
  input  logic              res_ready_i,
  output logic              walk_ready_o,
  output logic              mem_req_valid_o,
  output logic              sel_l2_o,
  output logic              res_valid_o,
  output logic [VPN_W-1:0]  vpn_q_o,
  output logic [BASE_W-1:0] base_q_o,
  output logic [PTR_W-1:0]  ptr_q_o,
  output walk_result_t      res_q_o
);
  walk_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      vpn_q_o  <= '0;
      base_q_o <= '0;
      ptr_q_o  <= '0;
      res_q_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (walk_valid_i) begin
          vpn_q_o  <= walk_vpn_i;
          base_q_o <= base_reg_i;
          state_q  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          if (l1_kind_i == L1_TABLE) begin
            ptr_q_o <= l1_ptr_i;
            state_q <= ST_L2_REQ;
          end else begin
            res_q_o <= l1_res_i;
            state_q <= ST_DONE;
          end
        end
        ST_L2_REQ: if (mem_req_ready_i) state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          res_q_o <= l2_res_i;
          state_q <= ST_DONE;
        end
        ST_DONE: if (res_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign walk_ready_o    = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign sel_l2_o        = (state_q == ST_L2_REQ);
  assign res_valid_o     = (state_q == ST_DONE);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              walk_valid_i,
  output logic              walk_ready_o,
  input  logic [VPN_W-1:0]  walk_vpn_i,
  input  logic [BASE_W-1:0] base_reg_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  output logic              mem_req_wide_o,
  input  logic              mem_rsp_valid_i,
  input  logic [RSP_W-1:0]  mem_rsp_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [PPN_W-1:0]  res_ppn_o,
  output logic              res_big_o,
  output logic              res_fault_o
);
  l1_kind_e          l1_kind;
  logic [PTR_W-1:0]  l1_ptr;
  walk_result_t      l1_res, l2_res, res_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [BASE_W-1:0] base_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              sel_l2;

  pt_entry_decode u_decode (
    .data_i    (mem_rsp_data_i),
    .vpn_i     (vpn_q),
    .l1_kind_o (l1_kind),
    .l1_ptr_o  (l1_ptr),
    .l1_res_o  (l1_res),
    .l2_res_o  (l2_res)
  );

  pt_walk_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .walk_valid_i    (walk_valid_i),
    .walk_vpn_i      (walk_vpn_i),
    .base_reg_i      (base_reg_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .l1_kind_i       (l1_kind),
    .l1_ptr_i        (l1_ptr),
    .l1_res_i        (l1_res),
    .l2_res_i        (l2_res),
    .res_ready_i     (res_ready_i),
    .walk_ready_o    (walk_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .sel_l2_o        (sel_l2),
    .res_valid_o     (res_valid_o),
    .vpn_q_o         (vpn_q),
    .base_q_o        (base_q),
    .ptr_q_o         (ptr_q),
    .res_q_o         (res_q)
  );

  pt_addr_gen u_addr (
    .base_i   (base_q),
    .vpn_i    (vpn_q),
    .ptr_i    (ptr_q),
    .sel_l2_i (sel_l2),
    .addr_o   (mem_req_addr_o),
    .wide_o   (mem_req_wide_o)
  );

  assign res_ppn_o   = res_q.ppn;
  assign res_big_o   = res_q.big;
  assign res_fault_o = res_q.fault;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             walk_valid_i,
  input logic             walk_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             mem_req_wide_o,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [PPN_W-1:0] res_ppn_o,
  input logic             res_big_o,
  input logic             res_fault_o
);
  AST_SINGLE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready_o |-> !mem_req_valid_o && !res_valid_o); // R2

  AST_L1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid_i && walk_ready_o |=> mem_req_valid_o && !mem_req_wide_o); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_wide_o)); // R3

  AST_FAULT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_fault_o |-> !res_big_o && (res_ppn_o == '0)); // R4

  AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && mem_req_wide_o |-> (mem_req_addr_o[L2_ENT_LG-1:0] == '0)); // R6

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=>
      res_valid_o && $stable(res_ppn_o) && $stable(res_big_o) && $stable(res_fault_o)); // R9

  AST_RES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_ready_i |=> walk_ready_o && !res_valid_o); // R9
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        walk_valid_i = 1'b0;
  logic        walk_ready_o;
  logic [19:0] walk_vpn_i = '0;
  logic [26:0] base_reg_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [39:0] mem_req_addr_o;
  logic        mem_req_wide_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;
  logic        res_valid_o;
  logic        res_ready_i = 1'b0;
  logic [27:0] res_ppn_o;
  logic        res_big_o;
  logic        res_fault_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_l1_addr(logic [26:0] b, logic [19:0] v);
    return {b, v[19:9], 2'b00};
  endfunction
  function automatic logic [39:0] exp_l2_addr(logic [31:0] e, logic [19:0] v);
    return {e[27:0], v[8:0], 3'b000};
  endfunction

  task automatic wait_req();
    for (int t = 0; t < 40 && !mem_req_valid_o; t++) @(negedge clk);
  endtask

  // Grant a pending request after d cycles, pulsing a stray response meanwhile
  task automatic grant(input int d);
    for (int i = 0; i < d; i++) begin
      mem_rsp_valid_i = (i == 0);            // R10 stray pulse while request waits
      mem_rsp_data_i  = {$urandom, $urandom};
      @(negedge clk);
    end
    mem_rsp_valid_i = 1'b0;
    mem_req_ready_i = 1'b1;
    @(negedge clk);
    mem_req_ready_i = 1'b0;
  endtask

  task automatic respond(input int d, input logic [63:0] data);
    for (int i = 0; i < d; i++) @(negedge clk);
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = data;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = {$urandom, $urandom};
  endtask

  task automatic do_walk(input logic [19:0] vpn, input logic [26:0] base,
                         input logic [31:0] l1e, input logic [63:0] l2e);
    logic        exp_fault, exp_big, table_walk;
    logic [27:0] exp_ppn;
    int          hold;
    table_walk = l1e[31] && !l1e[30];
    if (!l1e[31])       begin exp_fault = 1; exp_big = 0; exp_ppn = '0; end
    else if (l1e[30])   begin exp_fault = 0; exp_big = 1; exp_ppn = {l1e[18:0], vpn[8:0]}; end
    else if (!l2e[63])  begin exp_fault = 1; exp_big = 0; exp_ppn = '0; end
    else                begin exp_fault = 0; exp_big = 0; exp_ppn = l2e[27:0]; end

    for (int t = 0; t < 40 && !walk_ready_o; t++) @(negedge clk);
    check(walk_ready_o, "R2 idle before walk", walk_ready_o, 1);
    walk_valid_i = 1'b1;
    walk_vpn_i   = vpn;
    base_reg_i   = base;
    @(negedge clk);
    walk_valid_i = ($urandom % 2) == 1;      // holding valid must not start a second walk
    walk_vpn_i   = $urandom;                 // R11 inputs change mid-walk
    base_reg_i   = $urandom;
    check(!walk_ready_o, "R2 busy after accept", walk_ready_o, 0);
    check(mem_req_valid_o && !mem_req_wide_o, "R3 L1 request next cycle",
          {mem_req_valid_o, mem_req_wide_o}, 2'b10);
    check(mem_req_addr_o == exp_l1_addr(base, vpn), "R3 R11 L1 address",
          mem_req_addr_o, exp_l1_addr(base, vpn));
    grant($urandom % 4);
    check(mem_req_valid_o == 0, "R3 request drops after ready", mem_req_valid_o, 0);
    respond($urandom % 3, {$urandom, l1e});
    if (table_walk) begin
      check(mem_req_valid_o && mem_req_wide_o, "R6 L2 request next cycle",
            {mem_req_valid_o, mem_req_wide_o}, 2'b11);
      check(mem_req_addr_o == exp_l2_addr(l1e, vpn), "R6 R11 L2 address",
            mem_req_addr_o, exp_l2_addr(l1e, vpn));
      grant($urandom % 4);
      respond($urandom % 3, l2e);
    end else begin
      check(!mem_req_valid_o, l1e[31] ? "R5 no second read" : "R4 no second read",
            mem_req_valid_o, 0);
    end
    check(res_valid_o, "R9 result next cycle", res_valid_o, 1);
    hold = $urandom % 4;
    for (int i = 0; i <= hold; i++) begin
      check({res_fault_o, res_big_o, res_ppn_o} == {exp_fault, exp_big, exp_ppn},
            !table_walk ? (l1e[31] ? "R5 big page result" : "R4 L1 fault result")
                        : (l2e[63] ? "R7 L2 result" : "R8 L2 fault result"),
            {res_fault_o, res_big_o, res_ppn_o}, {exp_fault, exp_big, exp_ppn});
      if (i < hold) begin
        mem_rsp_valid_i = (i == 0);          // R10 stray pulse while result held
        mem_rsp_data_i  = {$urandom, $urandom};
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        check(res_valid_o, "R9 result held", res_valid_o, 1);
      end
    end
    walk_valid_i = 1'b0;
    res_ready_i  = 1'b1;
    @(negedge clk);
    res_ready_i  = 1'b0;
    check(walk_ready_o && !res_valid_o, "R9 idle after hand-off",
          {walk_ready_o, res_valid_o}, 2'b10);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(walk_ready_o && !mem_req_valid_o && !res_valid_o, "R1 reset state",
          {walk_ready_o, mem_req_valid_o, res_valid_o}, 3'b100);
    // R10 stray response while idle must not start anything
    mem_rsp_valid_i = 1'b1;
    mem_rsp_data_i  = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0;
    @(negedge clk);
    check(walk_ready_o && !res_valid_o && !mem_req_valid_o, "R10 idle ignores response",
          {walk_ready_o, res_valid_o, mem_req_valid_o}, 3'b100);

    // directed corners
    do_walk(20'hFFFFF, 27'h7FF_FFFF, 32'hC007_FFFF, 64'h0);        // R5 extremes
    do_walk(20'h00000, 27'h000_0000, 32'hFFFF_FFFF, 64'h0);        // R5 junk bits 29:19
    do_walk(20'h12345, 27'h155_5555, 32'h7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R4
    do_walk(20'hFFFFF, 27'h7FF_FFFF, 32'h8FFF_FFFF, 64'h8000_0000_0FFF_FFFF); // R6 R7
    do_walk(20'h001FF, 27'h000_0001, 32'hB000_0000, 64'h7FFF_FFFF_FFFF_FFFF); // R8
    do_walk(20'hABCDE, 27'h2AA_AAAA, 32'h8123_4567, 64'hFFFF_FFFF_F765_4321); // R7 junk

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] l1e;
      logic [63:0] l2e;
      l1e = $urandom;
      l1e[31] = ($urandom % 8) != 0;
      l2e = {$urandom, $urandom};
      l2e[63] = ($urandom % 8) != 0;
      do_walk($urandom, $urandom, l1e, l2e);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule